// File: doc/BRIEF.md
# Bitwise Lookup-Table Logic Unit

This execution slice evaluates one bitwise truth table across every bit position of a general register. It has two operations. The three-input operation indexes an 8-entry table taken from an immediate. The bit of the destination's current value is the top index bit, so the operation reads and then rewrites its destination. The two-input operation indexes a 4-entry table that arrives at run time as a nibble of a third register. A flag picks which of the two lowest nibbles is used, so two of these operations and one three-input merge can build a dynamic three-input lookup.

The issuing stage presents operands together with a one-cycle valid strobe. One clock later the unit presents the result and a valid pulse. When the three-input operation is issued with its record flag set, the unit also presents a condition-field-0 update.

Top module: `lut_logic_unit`

## Requirements
- R1: For the three-input operation (`op_sel`=0), bit i of the result equals bit j of `imm_tbl`, where j = 4·`dst_old`[i] + 2·`src_a`[i] + `src_b`[i]. Table bit 0 is the least significant bit of `imm_tbl`.
- R2: With `imm_tbl`=8'hD8, the three-input operation returns `src_a` in the positions where `src_b` is 1 and `dst_old` in the positions where `src_b` is 0.
- R3: For the two-input operation (`op_sel`=1) with `nib_hi`=0, bit i of the result equals bit j of `src_c`[3:0], where j = 2·`src_a`[i] + `src_b`[i].
- R4: For the two-input operation with `nib_hi`=1, the table is `src_c`[7:4], indexed in the same way as in R3.
- R5: The two-input operation never updates the condition field. After it completes, `cr_we` and `cr_val` are 0 whatever the value of `rec_en`.
- R6: A three-input operation with `rec_en`=1 gives `cr_we`=1. `cr_val`[3] (less) is set for a negative signed result, `cr_val`[2] (greater) for a positive one and `cr_val`[1] (equal) for zero, with exactly one of these three set. `cr_val`[0] copies `so_in`.
- R7: A three-input operation with `rec_en`=0 gives `cr_we`=0 and `cr_val`=0.
- R8: The result and the condition update appear on the clock edge after `in_valid`. `out_valid` is high for exactly the cycles that follow an `in_valid` cycle, and `result` holds its value while no strobe arrives.
- R9: After reset, `out_valid`, `result`, `cr_we` and `cr_val` are all 0.
- R10: Each operation ignores the table source that belongs to the other operation. `src_c` and `nib_hi` have no effect on the three-input result, and `imm_tbl` has no effect on the two-input result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| op_sel | input | 1 | 0 selects the three-input operation, 1 selects the two-input operation |
| dst_old | input | DATA_W | Current destination value (top index bit for the three-input operation) |
| src_a | input | DATA_W | First source |
| src_b | input | DATA_W | Second source |
| src_c | input | DATA_W | Register that supplies the two-input table |
| imm_tbl | input | 8 | Immediate table for the three-input operation |
| nib_hi | input | 1 | Selects the two-input table nibble (0: bits 3:0, 1: bits 7:4) |
| rec_en | input | 1 | Request a condition-field-0 update |
| so_in | input | 1 | Summary-overflow bit copied into the condition field |
| out_valid | output | 1 | Result valid pulse |
| result | output | DATA_W | Registered result |
| cr_we | output | 1 | Condition field write enable |
| cr_val | output | 4 | Condition field value {less, greater, equal, overflow} |

## Verification
The bench builds the unit with DATA_W at its default of 64. This places the sign bit that the less/greater decision reads at position 63, and it puts both candidate table nibbles inside the third operand. The vectors cover patterns that split into upper and lower halves and patterns that set only the top bit. These check that the table index is formed identically in every position and that the signed compare sees the true sign bit.

// File: rtl/lut_pkg.sv
package lut_pkg;
    localparam int TERN_TBL_W = 8;
    localparam int BIN_TBL_W  = 4;
    localparam int CR_W       = 4;
    localparam int CR_LT      = 3;
    localparam int CR_GT      = 2;
    localparam int CR_EQ      = 1;
    localparam int CR_SO      = 0;

    typedef enum logic {
        OP_TERN = 1'b0,
        OP_BIN  = 1'b1
    } lut_op_e;
endpackage

// File: rtl/lut_tern_array.sv
module lut_tern_array #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0]               d_in,
    input  logic [DATA_W-1:0]               a_in,
    input  logic [DATA_W-1:0]               b_in,
    input  logic [lut_pkg::TERN_TBL_W-1:0]  tbl,
    output logic [DATA_W-1:0]               y
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        logic [2:0] idx;
        assign idx  = {d_in[i], a_in[i], b_in[i]};
        assign y[i] = tbl[idx];
    end
endmodule

// File: rtl/lut_bin_array.sv
module lut_bin_array #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0]              a_in,
    input  logic [DATA_W-1:0]              b_in,
    input  logic [lut_pkg::BIN_TBL_W-1:0]  tbl,
    output logic [DATA_W-1:0]              y
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        logic [1:0] idx;
        assign idx  = {a_in[i], b_in[i]};
        assign y[i] = tbl[idx];
    end
endmodule

// File: rtl/lut_cr_eval.sv
module lut_cr_eval #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0]          res,
    input  logic                       so,
    output logic [lut_pkg::CR_W-1:0]   cr
);
    logic neg;
    logic zero;

    always_comb begin
        neg  = res[DATA_W-1];
        zero = (res == '0);
        cr   = '0;
        cr[lut_pkg::CR_LT] = neg;
        cr[lut_pkg::CR_GT] = !neg && !zero;
        cr[lut_pkg::CR_EQ] = zero;
        cr[lut_pkg::CR_SO] = so;
    end
endmodule

// File: rtl/lut_logic_unit.sv
module lut_logic_unit #(
    parameter int DATA_W = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic                      op_sel,
    input  logic [DATA_W-1:0]         dst_old,
    input  logic [DATA_W-1:0]         src_a,
    input  logic [DATA_W-1:0]         src_b,
    input  logic [DATA_W-1:0]         src_c,
    input  logic [7:0]                imm_tbl,
    input  logic                      nib_hi,
    input  logic                      rec_en,
    input  logic                      so_in,
    output logic                      out_valid,
    output logic [DATA_W-1:0]         result,
    output logic                      cr_we,
    output logic [3:0]                cr_val
);
    import lut_pkg::*;

    localparam int NIB_W    = BIN_TBL_W;
    localparam int TBL_SRC_W = 2 * NIB_W;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] res;
        logic              cr_we;
        logic [CR_W-1:0]   cr;
    } unit_st_t;

    unit_st_t st_d, st_q;

    logic [NIB_W-1:0]  bin_tbl;
    logic [DATA_W-1:0] tern_y;
    logic [DATA_W-1:0] bin_y;
    logic [CR_W-1:0]   cr_calc;
    logic              unused_tbl_hi;

    assign bin_tbl       = nib_hi ? src_c[TBL_SRC_W-1:NIB_W] : src_c[NIB_W-1:0];
    assign unused_tbl_hi = ^src_c[DATA_W-1:TBL_SRC_W];

    lut_tern_array #(.DATA_W(DATA_W)) u_tern (
        .d_in (dst_old),
        .a_in (src_a),
        .b_in (src_b),
        .tbl  (imm_tbl),
        .y    (tern_y)
    );

    lut_bin_array #(.DATA_W(DATA_W)) u_bin (
        .a_in (src_a),
        .b_in (src_b),
        .tbl  (bin_tbl),
        .y    (bin_y)
    );

    lut_cr_eval #(.DATA_W(DATA_W)) u_cr (
        .res (tern_y),
        .so  (so_in),
        .cr  (cr_calc)
    );

    always_comb begin
        st_d       = st_q;
        st_d.vld   = in_valid;
        st_d.cr_we = in_valid && (op_sel == OP_TERN) && rec_en;
        st_d.cr    = st_d.cr_we ? cr_calc : '0;
        if (in_valid) begin
            st_d.res = (op_sel == OP_BIN) ? bin_y : tern_y;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.res;
    assign cr_we     = st_q.cr_we;
    assign cr_val    = st_q.cr;
endmodule

// File: rtl/lut_logic_unit_chk.sv
module lut_logic_unit_chk #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              op_sel,
    input logic              rec_en,
    input logic              so_in,
    input logic              out_valid,
    input logic [DATA_W-1:0] result,
    input logic              cr_we,
    input logic [3:0]        cr_val
);
    assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_no_spurious_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));

    assert_cr_only_tern_rec_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cr_we |-> $past(in_valid && !op_sel && rec_en));

    assert_no_cr_without_rec_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !rec_en) |=> (!cr_we && cr_val == 4'd0));

    assert_cr_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cr_we |-> ($countones(cr_val[3:1]) == 1));

    assert_cr_eq_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cr_we |-> (cr_val[1] == (result == '0)));

    assert_cr_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cr_we |-> (cr_val[3] == result[DATA_W-1]));

    assert_cr_so_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cr_we |-> (cr_val[0] == $past(so_in)));
endmodule

bind lut_logic_unit lut_logic_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_sel    (op_sel),
    .rec_en    (rec_en),
    .so_in     (so_in),
    .out_valid (out_valid),
    .result    (result),
    .cr_we     (cr_we),
    .cr_val    (cr_val)
);

// File: tb/lut_logic_unit_tb.sv
module lut_logic_unit_tb;
    localparam int CLK_P  = 10;
    localparam int DW     = 64;
    localparam int NVEC   = 10;

    typedef struct packed {
        logic          op;
        logic [63:0]   d;
        logic [63:0]   a;
        logic [63:0]   b;
        logic [63:0]   c;
        logic [7:0]    imm;
        logic          nh;
        logic          rec;
        logic          so;
        logic [63:0]   exp_res;
        logic          exp_we;
        logic [3:0]    exp_cr;
    } vec_t;

    // R1 all-zero index; R1/R6 zero result; R2 mux; R1/R6 parity; R7;
    // R3 xor; R4 upper nibble; R3/R10 and; R10/R6 copy-d; R10/R6 copy-a
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 64'h0, 64'h0, 64'h0, 64'h0, 8'h01, 1'b0, 1'b1, 1'b0,
          64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 4'b1000},
        '{1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h0, 64'h0, 8'hEF, 1'b0, 1'b1, 1'b1,
          64'h0, 1'b1, 4'b0011},
        '{1'b0, 64'h0000_0000_FFFF_FFFF, 64'hAAAA_AAAA_AAAA_AAAA, 64'hFF00_FF00_FF00_FF00,
          64'h0, 8'hD8, 1'b0, 1'b1, 1'b0, 64'hAA00_AA00_AAFF_AAFF, 1'b1, 4'b1000},
        '{1'b0, 64'h1, 64'h2, 64'h4, 64'h0, 8'h96, 1'b0, 1'b1, 1'b0,
          64'h7, 1'b1, 4'b0100},
        '{1'b0, 64'h0, 64'h10, 64'h0, 64'h0, 8'hFE, 1'b0, 1'b0, 1'b1,
          64'h10, 1'b0, 4'b0000},
        '{1'b1, 64'h0, 64'hF0F0, 64'hFF00, 64'hF6, 8'h00, 1'b0, 1'b1, 1'b1,
          64'h0FF0, 1'b0, 4'b0000},
        '{1'b1, 64'h0, 64'h1234, 64'h5678, 64'hF6, 8'h00, 1'b1, 1'b1, 1'b0,
          64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 4'b0000},
        '{1'b1, 64'h0, 64'hFFFF_0000_FFFF_0000, 64'hFF00_FF00_FF00_FF00, 64'h8, 8'hFF,
          1'b0, 1'b0, 1'b0, 64'hFF00_0000_FF00_0000, 1'b0, 4'b0000},
        '{1'b0, 64'h8000_0000_0000_0000, 64'h0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 8'hF0,
          1'b1, 1'b1, 1'b1, 64'h8000_0000_0000_0000, 1'b1, 4'b1001},
        '{1'b0, 64'h1, 64'h7FFF_FFFF_FFFF_FFFF, 64'h0, 64'h5A5A, 8'hCC, 1'b0, 1'b1, 1'b1,
          64'h7FFF_FFFF_FFFF_FFFF, 1'b1, 4'b0101}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          op_sel = 1'b0;
    logic [DW-1:0] dst_old = '0;
    logic [DW-1:0] src_a = '0;
    logic [DW-1:0] src_b = '0;
    logic [DW-1:0] src_c = '0;
    logic [7:0]    imm_tbl = '0;
    logic          nib_hi = 1'b0;
    logic          rec_en = 1'b0;
    logic          so_in = 1'b0;
    logic          out_valid;
    logic [DW-1:0] result;
    logic          cr_we;
    logic [3:0]    cr_val;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    lut_logic_unit #(.DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .dst_old(dst_old), .src_a(src_a), .src_b(src_b), .src_c(src_c),
        .imm_tbl(imm_tbl), .nib_hi(nib_hi), .rec_en(rec_en), .so_in(so_in),
        .out_valid(out_valid), .result(result), .cr_we(cr_we), .cr_val(cr_val)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        op_sel = v.op; dst_old = v.d; src_a = v.a; src_b = v.b; src_c = v.c;
        imm_tbl = v.imm; nib_hi = v.nh; rec_en = v.rec; so_in = v.so;
    endtask

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9 valid", 64'(out_valid), 64'd0);
        check("R9 result", result, 64'd0);
        check("R9 cr_we", 64'(cr_we), 64'd0);
        check("R9 cr_val", 64'(cr_val), 64'd0);
        rst_n = 1'b1;

        for (int k = 0; k < NVEC; k++) begin
            @(negedge clk);
            drive(VECS[k]);
            in_valid = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            check($sformatf("R8 valid v%0d", k), 64'(out_valid), 64'd1);
            check($sformatf("R1/R3 result v%0d", k), result, VECS[k].exp_res);
            check($sformatf("R5/R6/R7 cr_we v%0d", k), 64'(cr_we), 64'(VECS[k].exp_we));
            check($sformatf("R6 cr_val v%0d", k), 64'(cr_val), 64'(VECS[k].exp_cr));
        end

        // R8: no strobe -> valid drops, result held although inputs change
        src_a = 64'h1111; src_b = 64'h2222; imm_tbl = 8'h55;
        @(negedge clk);
        check("R8 valid low", 64'(out_valid), 64'd0);
        check("R8 hold", result, VECS[NVEC-1].exp_res);
        check("R8 no cr", 64'(cr_we), 64'd0);

        // R10: changing src_c/nib_hi does not alter the ternary result
        drive(VECS[2]);
        src_c = 64'hFFFF_FFFF_FFFF_FFFF; nib_hi = 1'b1;
        in_valid = 1'b1;
        @(negedge clk);
        // back-to-back strobe: two-input op with a different immediate (R10)
        drive(VECS[7]);
        imm_tbl = 8'h3C;
        check("R10 tern ignores src_c", result, VECS[2].exp_res);
        @(negedge clk);
        in_valid = 1'b0;
        check("R8 back-to-back valid", 64'(out_valid), 64'd1);
        check("R10 bin ignores imm", result, VECS[7].exp_res);
        check("R5 bin no cr_val", 64'(cr_val), 64'd0);

        // R9: reset mid-run clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 re-reset result", result, 64'd0);
        check("R9 re-reset valid", 64'(out_valid), 64'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule